// File: doc/BRIEF.md
# Serial Character Transmitter with Break Sequencing

This block turns bytes into asynchronous serial frames on a single output line. A one-entry holding register takes characters from a valid/ready write port and feeds a shift register. The shift register sends each frame: one low start bit, five to eight data bits with the least significant bit first, an optional parity or address bit, and one high stop bit. Each bit lasts a fixed number of pulses of the `baud_tick` input, which an outside rate generator supplies.

Single-cycle command pulses turn the transmitter on and off, request and end a line break, and mark the next character as an address for multidrop links. A break waits until every pending character has gone out. It then holds the line low for at least one character time. When it ends, the line stays high for a fixed guard of twelve bit periods before the next character may start. The write port applies back-pressure: `wr_ready` is low while the holding register is occupied. A word is taken only on a cycle where `wr_valid` and `wr_ready` are both high, and `wr_data` must stay stable until then.

Top module: `sertx_break`

## Requirements
- R1: After reset, `txd` is 1, `wr_ready` is 1, `tx_empty` is 1, and the transmitter is disabled.
- R2: A frame is a 0 start bit, then `5 + cfg_len` data bits sent least significant bit first, then the optional parity slot, then a 1 stop bit. Every bit lasts 16 `baud_tick` pulses. `cfg_len` is 0..3, giving 5..8 data bits.
- R3: `cfg_par` selects the parity slot. 0 sends even parity: the bit is 1 when the data bits hold an odd number of ones. 1 sends odd parity, 2 sends a constant 0, and 3 sends a constant 1. Codes 4, 5 and 7 send no parity slot.
- R4: With `cfg_par` = 6 (multidrop), the parity slot carries an address flag. The flag is 1 only for the first write accepted in the same cycle as, or after, a `cmd_addr_next` pulse. The pulse is consumed by that one write, and every other character carries 0.
- R5: `wr_ready` is high exactly when the holding register is empty. A word is captured when `wr_valid` and `wr_ready` are both high. A captured word is never overwritten before it is sent.
- R6: A `cmd_tx_on` pulse enables the transmitter unless `cmd_tx_off` is high in the same cycle, and `cmd_tx_off` always disables it. A character already being shifted out finishes. While disabled, a captured word stays in the holding register and is not sent.
- R7: `tx_empty` is high only when the holding register is empty, no frame is being shifted, and no break (waiting, low or guard) is under way.
- R8: `cmd_brk_start` makes the line go low only after the holding register and the shift register have both finished their characters.
- R9: A `cmd_brk_start` pulse is ignored while a break is already waiting, low, or in its guard period.
- R10: `cmd_brk_stop` acts only while the line is held low by a break. The low period then ends no sooner than one full frame length at the current configuration (frame bits × 16 ticks). A stop pulse at any other time has no effect.
- R11: After a break ends, `txd` stays 1 for 12 bit periods (192 ticks), and no character starts during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| cmd_tx_on | input | 1 | Enable pulse for the transmitter |
| cmd_tx_off | input | 1 | Disable pulse for the transmitter; wins over enable |
| cmd_brk_start | input | 1 | Request a line break |
| cmd_brk_stop | input | 1 | End a break in progress |
| cmd_addr_next | input | 1 | Mark the next written character as an address |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_par | input | 3 | Parity slot mode |
| wr_valid | input | 1 | Write word is valid |
| wr_data | input | 8 | Write word |
| wr_ready | output | 1 | Holding register empty, ready to accept a write |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register, shifter and break logic all idle |

## Verification
The hardest state to reach is a break stacked behind live traffic. It needs a character in the shifter when the break request arrives, a second start request and a stop request during the low phase, and a new character waiting in the holding register through the guard. The bench gets there with directed sequences timed against its own count of baud ticks. It measures the low and guard durations in ticks, then decodes the queued character. Random frames over every length and parity code, with address marks on random writes, cover the frame format.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W = 8;
  localparam int FRAME_W = DATA_W + 3;

  localparam logic [2:0] PAR_EVEN  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_ZERO  = 3'd2;
  localparam logic [2:0] PAR_ONE   = 3'd3;
  localparam logic [2:0] PAR_MDROP = 3'd6;

  typedef enum logic [1:0] {BRK_IDLE, BRK_WAIT, BRK_LOW, BRK_GUARD} brk_state_e;

  function automatic logic par_used(input logic [2:0] p);
    return (p <= PAR_ONE) || (p == PAR_MDROP);
  endfunction

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [3:0] frame_bits(input logic [1:0] len, input logic [2:0] p);
    return data_bits(len) + 4'd2 + {3'b000, par_used(p)};
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_cmd,
  input  logic              take,
  output logic              wr_ready,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              addr
);
  logic              full_q, arm_q, addr_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;

  assign fire     = wr_valid && !full_q;
  assign wr_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;
  assign addr     = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      addr_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (take) begin
        full_q <= 1'b0;
      end else if (fire) begin
        full_q <= 1'b1;
        data_q <= wr_data;
        addr_q <= arm_q || addr_cmd;
      end
      if (fire)          arm_q <= 1'b0;
      else if (addr_cmd) arm_q <= 1'b1;
    end
  end

  // R5: a held word stays put until the shifter takes it
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> ($stable(data_q) && full_q));
  // R5: the shifter only takes from an occupied holding register
  a_r5_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              addr,
  input  logic [1:0]        len,
  input  logic [2:0]        par,
  output logic              busy,
  output logic              line
);
  localparam int TW = $clog2(TPB + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TPB - 1);

  logic [FRAME_W-1:0] sh_q, frame;
  logic [3:0]         left_q;
  logic [TW-1:0]      tick_q;
  logic               busy_q;
  logic [3:0]         n;
  logic [DATA_W-1:0]  mask, dm;
  logic               pbit;

  always_comb begin
    n    = data_bits(len);
    mask = DATA_W'((9'd1 << n) - 9'd1);
    dm   = data & mask;
    case (par)
      PAR_EVEN:  pbit = ^dm;
      PAR_ODD:   pbit = ~^dm;
      PAR_ONE:   pbit = 1'b1;
      PAR_MDROP: pbit = addr;
      default:   pbit = 1'b0;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n)) frame[i+1] = data[i];
    end
    if (par_used(par)) frame[int'(n) + 1] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= frame;
      left_q <= frame_bits(len, par);
      tick_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;

  // R2: no new frame may be loaded over one in flight
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load);
  // R2: a busy shifter always has bits left to send
  a_r2_bits_left: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != 4'd0));
endmodule

// File: rtl/sertx_brk.sv
module sertx_brk
  import sertx_pkg::*;
#(
  parameter int TPB        = 16,
  parameter int GUARD_BITS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       stop,
  input  logic       hold_full,
  input  logic       sh_busy,
  input  logic [3:0] char_bits,
  output logic       low,
  output logic       active,
  output logic       block
);
  localparam int MAXB = (GUARD_BITS > FRAME_W) ? GUARD_BITS : FRAME_W;
  localparam int CW   = $clog2(MAXB * TPB + 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_BITS * TPB - 1);

  brk_state_e    st_q;
  logic [CW-1:0] cnt_q, lim;
  logic          stop_q;

  assign lim = CW'(int'(char_bits) * TPB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BRK_IDLE;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      case (st_q)
        BRK_IDLE: if (start) st_q <= BRK_WAIT;
        BRK_WAIT: if (!hold_full && !sh_busy) begin
          st_q   <= BRK_LOW;
          cnt_q  <= '0;
          stop_q <= 1'b0;
        end
        BRK_LOW: begin
          if (stop) stop_q <= 1'b1;
          if (tick && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
          if (stop_q && (cnt_q >= lim)) begin
            st_q  <= BRK_GUARD;
            cnt_q <= '0;
          end
        end
        default: if (tick) begin
          if (cnt_q == GUARD_LAST) st_q <= BRK_IDLE;
          else                     cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign low    = (st_q == BRK_LOW);
  assign active = (st_q != BRK_IDLE);
  assign block  = (st_q == BRK_LOW) || (st_q == BRK_GUARD);

  // R8: the line is only pulled low once the shifter has drained
  a_r8_low_line_free: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BRK_LOW) |-> !sh_busy);
  // R11: no frame is in flight during the guard period
  a_r11_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BRK_GUARD) |-> !sh_busy);
endmodule

// File: rtl/sertx_break.sv
module sertx_break
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int GUARD_BITS    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cmd_tx_on,
  input  logic       cmd_tx_off,
  input  logic       cmd_brk_start,
  input  logic       cmd_brk_stop,
  input  logic       cmd_addr_next,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       txd,
  output logic       tx_empty
);
  logic              en_q, load;
  logic              hold_full, hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy, sh_line;
  logic              brk_low, brk_active, brk_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (cmd_tx_off) en_q <= 1'b0;
    else if (cmd_tx_on)  en_q <= 1'b1;
  end

  assign load = en_q && hold_full && !sh_busy && !brk_block;

  sertx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .addr_cmd(cmd_addr_next), .take(load), .wr_ready(wr_ready),
    .full(hold_full), .data(hold_data), .addr(hold_addr)
  );

  sertx_shift #(.TPB(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load),
    .data(hold_data), .addr(hold_addr), .len(cfg_len), .par(cfg_par),
    .busy(sh_busy), .line(sh_line)
  );

  sertx_brk #(.TPB(TICKS_PER_BIT), .GUARD_BITS(GUARD_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(cmd_brk_start),
    .stop(cmd_brk_stop), .hold_full(hold_full), .sh_busy(sh_busy),
    .char_bits(frame_bits(cfg_len, cfg_par)), .low(brk_low),
    .active(brk_active), .block(brk_block)
  );

  assign txd      = sh_line && !brk_low;
  assign tx_empty = !hold_full && !sh_busy && !brk_active;

  // R7: an empty transmitter leaves the port ready and the line idle high
  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (wr_ready && txd));
  // R6: a disabled transmitter starts no frame
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !sh_busy) |=> !sh_busy);
endmodule

// File: tb/test_sertx_break.sv
`timescale 1ns/1ps
module test_sertx_break;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic       cmd_tx_on = 0, cmd_tx_off = 0, cmd_brk_start = 0, cmd_brk_stop = 0, cmd_addr_next = 0;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd4;
  logic       wr_valid = 0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, txd, tx_empty;
  int         n_chk = 0, n_fail = 0, tcnt = 0;

  sertx_break i_sertx_break (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cmd_tx_on(cmd_tx_on),
    .cmd_tx_off(cmd_tx_off), .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
    .cmd_addr_next(cmd_addr_next), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .txd(txd), .tx_empty(tx_empty)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) if (baud_tick) tcnt <= tcnt + 1;
  initial forever begin @(negedge clk); baud_tick = ~baud_tick; end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  function automatic logic par_on(input logic [2:0] p);
    return (p <= 3'd3) || (p == 3'd6);
  endfunction

  function automatic logic exp_par(input logic [2:0] p, input logic [1:0] l, input logic [7:0] d, input logic a);
    logic [7:0] m;
    m = d & 8'((9'd1 << (5 + l)) - 9'd1);
    case (p)
      3'd0: return ^m;
      3'd1: return ~^m;
      3'd3: return 1'b1;
      3'd6: return a;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_tick(input int target);
    while (tcnt < target) @(negedge clk);
  endtask

  task automatic wait_fall(output int t);
    while (txd !== 1'b0) @(negedge clk);
    t = tcnt;
  endtask

  task automatic wait_rise(output int t);
    while (txd !== 1'b1) @(negedge clk);
    t = tcnt;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_tx_on = 1;
      1: cmd_tx_off = 1;
      2: cmd_brk_start = 1;
      3: cmd_brk_stop = 1;
      4: cmd_addr_next = 1;
      default: begin cmd_tx_on = 1; cmd_tx_off = 1; end
    endcase
    @(negedge clk);
    {cmd_tx_on, cmd_tx_off, cmd_brk_start, cmd_brk_stop, cmd_addr_next} = '0;
  endtask

  task automatic write_char(input logic [7:0] d, input logic a);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d; cmd_addr_next = a;
    @(negedge clk);
    wr_valid = 0; cmd_addr_next = 0;
  endtask

  // decode one frame whose start bit was seen at tick t0
  task automatic rx_frame(input int t0, output logic [7:0] d, output logic pb, output logic sb);
    int k;
    d = 0; pb = 0;
    for (k = 1; k <= 5 + cfg_len; k++) begin
      wait_tick(t0 + 16 * k + 8);
      d[k-1] = txd;
    end
    if (par_on(cfg_par)) begin
      wait_tick(t0 + 16 * k + 8);
      pb = txd;
      k++;
    end
    wait_tick(t0 + 16 * k + 8);
    sb = txd;
  endtask

  task automatic send_check(input logic [7:0] d, input logic a, input logic exp_a, input string req);
    int t0;
    logic [7:0] rd, md;
    logic pb, sb;
    write_char(d, a);
    wait_fall(t0);
    rx_frame(t0, rd, pb, sb);
    md = d & 8'((9'd1 << (5 + cfg_len)) - 9'd1);
    check(rd == md, req, rd, md);
    if (par_on(cfg_par))
      check(pb == exp_par(cfg_par, cfg_len, d, exp_a), req, pb, exp_par(cfg_par, cfg_len, d, exp_a));
    check(sb == 1'b1, "R2", sb, 1);
  endtask

  initial begin
    int t0, t1, t2;
    logic [7:0] rd;
    logic pb, sb;
    logic [2:0] pars [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6, 3'd5};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1, "R1", txd, 1);
    check(wr_ready == 1, "R1", wr_ready, 1);
    check(tx_empty == 1, "R1", tx_empty, 1);
    // R1 disabled after reset: a write is held, not sent
    write_char(8'h55, 0);
    wait_tick(tcnt + 60);
    check(txd == 1, "R1", txd, 1);
    pulse(0);
    wait_fall(t0);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'h55, "R1", rd, 8'h55);

    // R2 R3 R4 random frames
    for (int it = 0; it < 30; it++) begin
      logic [1:0] l;
      logic [2:0] p;
      logic [7:0] d;
      logic a;
      l = 2'($urandom % 4);
      p = pars[$urandom % 7];
      d = 8'($urandom);
      a = 1'($urandom % 2);
      while (!tx_empty) @(negedge clk);
      cfg_len = l; cfg_par = p;
      send_check(d, a, a, (p == 3'd6) ? "R4" : "R3");
    end

    // R4 one-shot address mark given ahead of the write
    while (!tx_empty) @(negedge clk);
    cfg_len = 2'd3; cfg_par = 3'd6;
    pulse(4);
    send_check(8'hA5, 0, 1, "R4");
    send_check(8'h3C, 0, 0, "R4");
    cfg_par = 3'd4;

    // R6 disable keeps the word held; R5 back-pressure
    while (!tx_empty) @(negedge clk);
    pulse(1);
    write_char(8'hC3, 0);
    wait_tick(tcnt + 100);
    check(txd == 1, "R6", txd, 1);
    check(wr_ready == 0, "R5", wr_ready, 0);
    wr_valid = 1; wr_data = 8'h99;
    repeat (20) @(negedge clk);
    wr_valid = 0;
    pulse(5); // enable and disable together
    wait_tick(tcnt + 100);
    check(txd == 1, "R6", txd, 1);
    pulse(0);
    wait_fall(t0);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'hC3, "R5", rd, 8'hC3);

    // R6 disable during a frame lets it finish, then stops
    write_char(8'h0F, 0);
    wait_fall(t0);
    pulse(1);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'h0F, "R6", rd, 8'h0F);
    write_char(8'hE1, 0);
    wait_tick(tcnt + 100);
    check(txd == 1, "R6", txd, 1);
    pulse(0);
    wait_fall(t0);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'hE1, "R6", rd, 8'hE1);
    // R7 empty only after the stop bit (10-bit frame, 160 ticks)
    check(tx_empty == 0, "R7", tx_empty, 0);
    wait_tick(t0 + 163);
    check(tx_empty == 1, "R7", tx_empty, 1);

    // R10 stop while idle is ignored
    pulse(3);
    wait_tick(tcnt + 50);
    check(txd == 1, "R10", txd, 1);
    check(tx_empty == 1, "R10", tx_empty, 1);

    // R8 break queued behind a character
    write_char(8'h6B, 0);
    pulse(2);
    wait_fall(t0);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'h6B, "R8", rd, 8'h6B);
    wait_fall(t1);
    check(t1 - t0 >= 160, "R8", t1 - t0, 160);
    check(tx_empty == 0, "R7", tx_empty, 0);
    pulse(2); // R9 second start ignored
    pulse(3); // R10 early stop
    write_char(8'h96, 0);
    wait_rise(t2);
    check((t2 - t1 >= 160) && (t2 - t1 <= 163), "R10", t2 - t1, 160);
    check(wr_ready == 0, "R11", wr_ready, 0);
    wait_fall(t0);
    check((t0 - t2 >= 192) && (t0 - t2 <= 195), "R11", t0 - t2, 192);
    rx_frame(t0, rd, pb, sb);
    check(rd == 8'h96, "R11", rd, 8'h96);
    while (!tx_empty) @(negedge clk);
    wait_tick(tcnt + 300);
    check(txd == 1, "R9", txd, 1);
    check(tx_empty == 1, "R9", tx_empty, 1);

    // R10 long break held until stop
    pulse(2);
    wait_fall(t1);
    wait_tick(t1 + 300);
    check(txd == 0, "R10", txd, 0);
    pulse(3);
    wait_rise(t2);
    check((t2 - t1 >= 300) && (t2 - t1 <= 304), "R10", t2 - t1, 300);
    wait_tick(t2 + 180);
    check(tx_empty == 0, "R11", tx_empty, 0);
    wait_tick(t2 + 200);
    check(tx_empty == 1, "R11", tx_empty, 1);

    finish_run();
  end
endmodule